// File: doc/BRIEF.md
# Move-Driven Transport-Triggered Datapath

This block is the execution core of a processor in which instructions carry no operation codes. Each instruction holds several move slots. Every cycle, each slot copies one value from a source socket to a destination socket. A source socket is a register, the result port of a function unit, a short immediate held inside the move, the long immediate that travels with the instruction, the return program counter, or the boolean flag. A destination socket is a register, an operand or trigger port of a function unit, the program counter (absolute or relative), the boolean flag, or the output socket.

Operations happen as a side effect of the moves. An operand move loads a unit's operand latch. A trigger move starts the unit. The trigger address chooses the operation, and the trigger value is the second input. The result can be read by the following instruction and stays in place until the unit is triggered again. Each move can be made conditional on the boolean flag. All moves of one instruction read their sources before any destination is written.

The program counter advances by one for each instruction unless a move redirects it. The surrounding fetch logic uses the counter as the address of the next instruction.

Top module: `ttm_core`

## Requirements
- R1: During reset and immediately after it, pc, out_data, out_valid and conflict_err are all 0. All registers, operand latches, result ports and the boolean flag are also 0.
- R2: Slot k occupies bits [14k+13:14k] of instr. Within a slot, bits [13:12] are the guard, bit [11] is the immediate flag, bits [10:5] are the source and bits [4:0] are the destination. Destination codes: 0..7 register; 16 adder operand; 17 add trigger; 18 subtract trigger; 19 comparator operand; 20 equal trigger; 21 signed less-than trigger; 24 program counter; 25 program counter displacement; 26 boolean flag; 27 output socket. Every other destination code is a no-op.
- R3: When the immediate flag is 1, the six source bits are sign-extended and used as the value. When the flag is 0, the source code selects the value: 0..7 register; 16 adder result; 17 comparator result; 18 limm; 19 pc+1; 20 the boolean flag. Any other source code gives 0.
- R4: Every move of an instruction reads its source before any destination is written. A register that is read and written in the same instruction therefore yields its old value, so two moves can swap two registers.
- R5: A trigger into 17 makes the adder result operand+value, and a trigger into 18 makes it operand−value. The operand is the latch content from before this instruction. The result can be read by the next instruction.
- R6: A trigger into 20 makes the comparator result 1 when operand==value and 0 otherwise. A trigger into 21 makes it 1 when operand<value as signed numbers and 0 otherwise.
- R7: A unit's result port keeps its value across instructions that do not trigger that unit.
- R8: Guard 0 always executes, guard 1 executes when the flag is 1, guard 2 executes when the flag is 0, and guard 3 never executes. A move that does not execute writes nothing and triggers nothing.
- R9: pc increments by 1 per instruction. A move into 24 loads pc with the value, and a move into 25 adds the value to the current pc. Together with source 19, this lets one instruction perform a call.
- R10: A move into 27 loads out_data, and out_valid is 1 during the following cycle only.
- R11: When two executing moves in one instruction target the same destination, the lower-numbered slot wins. Codes 17/18, 20/21 and 24/25 each count as one destination. The conflict sets conflict_err, which stays set until reset.
- R12: A move into 26 loads the boolean flag with bit 0 of the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr | input | NSLOT*14 | Move slots of the current instruction |
| limm | input | DW | Long immediate of the current instruction |
| pc | output | PCW | Program counter (address of the next instruction to fetch) |
| out_data | output | DW | Last value moved into the output socket |
| out_valid | output | 1 | Pulse marking an output-socket write |
| conflict_err | output | 1 | Sticky flag for a destination conflict |

## Verification
The directed patterns cover several cases, and each one separates a particular kind of fault. Sign-extended short immediates and long immediates catch errors in the immediate path. A two-register swap catches any write that becomes visible to reads in the same cycle. An operand and a trigger issued in the same instruction show whether the trigger uses the old operand latch. Guard-false triggers and guard-false output moves catch predication that does not suppress side effects. Jumps, relative branches and a call check the program counter path. A same-destination pair checks slot priority and the sticky flag. Finally, a long run of arbitrary move words is compared against a behavioural model on every clock, which exposes rare source/destination combinations.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
  localparam int GUARD_W = 2;
  localparam int SRC_W   = 6;
  localparam int DST_W   = 5;
  localparam int MOVE_W  = GUARD_W + 1 + SRC_W + DST_W;

  localparam logic [SRC_W-1:0] S_ADD_RES = 6'd16;
  localparam logic [SRC_W-1:0] S_CMP_RES = 6'd17;
  localparam logic [SRC_W-1:0] S_LIMM    = 6'd18;
  localparam logic [SRC_W-1:0] S_RETPC   = 6'd19;
  localparam logic [SRC_W-1:0] S_FLAG    = 6'd20;

  localparam logic [DST_W-1:0] D_ADD_OPND = 5'd16;
  localparam logic [DST_W-1:0] D_ADD_TRIG = 5'd17;
  localparam logic [DST_W-1:0] D_SUB_TRIG = 5'd18;
  localparam logic [DST_W-1:0] D_CMP_OPND = 5'd19;
  localparam logic [DST_W-1:0] D_EQ_TRIG  = 5'd20;
  localparam logic [DST_W-1:0] D_LT_TRIG  = 5'd21;
  localparam logic [DST_W-1:0] D_PC_ABS   = 5'd24;
  localparam logic [DST_W-1:0] D_PC_REL   = 5'd25;
  localparam logic [DST_W-1:0] D_FLAG     = 5'd26;
  localparam logic [DST_W-1:0] D_OUT      = 5'd27;
  localparam logic [DST_W-1:0] D_NONE     = 5'd31;

  // guard code: 0 always, 1 when flag set, 2 when flag clear, 3 never
  function automatic logic guard_pass(input logic [GUARD_W-1:0] g, input logic flag);
    case (g)
      2'd0:    return 1'b1;
      2'd1:    return flag;
      2'd2:    return !flag;
      default: return 1'b0;
    endcase
  endfunction

  // sockets sharing a unit or a register collapse to one conflict group
  function automatic logic [DST_W-1:0] dst_group(input logic [DST_W-1:0] d, input int nreg);
    if (int'(d) < nreg) return d;
    case (d)
      D_ADD_TRIG, D_SUB_TRIG: return D_ADD_TRIG;
      D_EQ_TRIG, D_LT_TRIG:   return D_EQ_TRIG;
      D_PC_ABS, D_PC_REL:     return D_PC_ABS;
      D_ADD_OPND, D_CMP_OPND, D_FLAG, D_OUT: return d;
      default:                return D_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ttm_regfile.sv
module ttm_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NREG-1:0] we,
  input  logic [DW-1:0] wd [NREG],
  output logic [DW-1:0] rd [NREG]
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd[r] <= '0;
      else if (we[r]) rd[r] <= wd[r];
    end
  end
endmodule

// File: rtl/ttm_fu.sv
module ttm_fu #(
  parameter int DW     = 32,
  parameter bit IS_CMP = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          opnd_we,
  input  logic [DW-1:0] opnd_d,
  input  logic          trig,
  input  logic          trig_alt,
  input  logic [DW-1:0] trig_d,
  output logic [DW-1:0] result
);
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] calc;

  function automatic logic [DW-1:0] add_sub(input logic alt, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return alt ? a - b : a + b;
  endfunction

  function automatic logic [DW-1:0] compare(input logic alt, input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic hit;
    hit = alt ? ($signed(a) < $signed(b)) : (a == b);
    return {{(DW-1){1'b0}}, hit};
  endfunction

  if (IS_CMP) begin : g_cmp
    assign calc = compare(trig_alt, opnd_q, trig_d);
  end else begin : g_add
    assign calc = add_sub(trig_alt, opnd_q, trig_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q <= '0;
      result <= '0;
    end else begin
      if (opnd_we) opnd_q <= opnd_d;
      if (trig)    result <= calc;
    end
  end

  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(result));
endmodule

// File: rtl/ttm_slot.sv
module ttm_slot
  import ttm_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int PCW  = 16
) (
  input  logic [MOVE_W-1:0] mv,
  input  logic [DW-1:0]     rf [NREG],
  input  logic [DW-1:0]     add_res,
  input  logic [DW-1:0]     cmp_res,
  input  logic [DW-1:0]     limm,
  input  logic [PCW-1:0]    ret_pc,
  input  logic              flag,
  output logic              act,
  output logic [DST_W-1:0]  dst,
  output logic [DW-1:0]     val
);
  localparam int RIW = $clog2(NREG);

  logic [GUARD_W-1:0] g;
  logic               imm;
  logic [SRC_W-1:0]   src;

  assign {g, imm, src, dst} = mv;
  assign act = guard_pass(g, flag) && (dst_group(dst, NREG) != D_NONE);

  always_comb begin
    if (imm)                     val = {{(DW-SW_PAD){src[SRC_W-1]}}, src};
    else if (int'(src) < NREG)   val = rf[src[RIW-1:0]];
    else begin
      case (src)
        S_ADD_RES: val = add_res;
        S_CMP_RES: val = cmp_res;
        S_LIMM:    val = limm;
        S_RETPC:   val = {{(DW-PCW){1'b0}}, ret_pc};
        S_FLAG:    val = {{(DW-1){1'b0}}, flag};
        default:   val = '0;
      endcase
    end
  end

  localparam int SW_PAD = SRC_W;
endmodule

// File: rtl/ttm_core.sv
module ttm_core
  import ttm_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int PCW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSLOT*MOVE_W-1:0] instr,
  input  logic [DW-1:0]           limm,
  output logic [PCW-1:0]          pc,
  output logic [DW-1:0]           out_data,
  output logic                    out_valid,
  output logic                    conflict_err
);
  localparam int RIW = $clog2(NREG);
  localparam logic [PCW-1:0] PC_ONE = PCW'(1);

  logic [DW-1:0]    rf [NREG];
  logic [DW-1:0]    add_res, cmp_res;
  logic             flag;
  logic [PCW-1:0]   ret_pc;
  logic             act [NSLOT];
  logic [DST_W-1:0] dst [NSLOT];
  logic [DW-1:0]    val [NSLOT];

  assign ret_pc = pc + PC_ONE;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    ttm_slot #(.DW(DW), .NREG(NREG), .PCW(PCW)) slot_i (
      .mv(instr[s*MOVE_W +: MOVE_W]), .rf(rf), .add_res(add_res), .cmp_res(cmp_res),
      .limm(limm), .ret_pc(ret_pc), .flag(flag),
      .act(act[s]), .dst(dst[s]), .val(val[s]));
  end

  // write steering: lower slots are visited last and so win
  logic [NREG-1:0] rf_we;
  logic [DW-1:0]   rf_wd [NREG];
  logic            a_op_we, a_trig, a_alt, c_op_we, c_trig, c_alt;
  logic [DW-1:0]   a_op_d, a_trig_d, c_op_d, c_trig_d;
  logic            pc_redirect, flag_we, out_we;
  logic [PCW-1:0]  pc_next;
  logic            flag_d;
  logic [DW-1:0]   out_d;

  always_comb begin
    rf_we = '0;
    for (int r = 0; r < NREG; r++) rf_wd[r] = '0;
    {a_op_we, a_trig, a_alt, c_op_we, c_trig, c_alt} = '0;
    {a_op_d, a_trig_d, c_op_d, c_trig_d} = '0;
    pc_redirect = 1'b0;
    pc_next = ret_pc;
    flag_we = 1'b0;
    flag_d  = 1'b0;
    out_we  = 1'b0;
    out_d   = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (act[s]) begin
        if (int'(dst[s]) < NREG) begin
          rf_we[dst[s][RIW-1:0]] = 1'b1;
          rf_wd[dst[s][RIW-1:0]] = val[s];
        end else begin
          case (dst[s])
            D_ADD_OPND: begin a_op_we = 1'b1; a_op_d = val[s]; end
            D_ADD_TRIG, D_SUB_TRIG: begin
              a_trig = 1'b1; a_alt = (dst[s] == D_SUB_TRIG); a_trig_d = val[s];
            end
            D_CMP_OPND: begin c_op_we = 1'b1; c_op_d = val[s]; end
            D_EQ_TRIG, D_LT_TRIG: begin
              c_trig = 1'b1; c_alt = (dst[s] == D_LT_TRIG); c_trig_d = val[s];
            end
            D_PC_ABS: begin pc_redirect = 1'b1; pc_next = val[s][PCW-1:0]; end
            D_PC_REL: begin pc_redirect = 1'b1; pc_next = pc + val[s][PCW-1:0]; end
            D_FLAG:   begin flag_we = 1'b1; flag_d = val[s][0]; end
            D_OUT:    begin out_we = 1'b1; out_d = val[s]; end
            default:  ;
          endcase
        end
      end
    end
  end

  // conflict detection between executing moves of one instruction
  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NSLOT; i++)
      for (int j = i + 1; j < NSLOT; j++)
        if (act[i] && act[j] && dst_group(dst[i], NREG) == dst_group(dst[j], NREG))
          clash = 1'b1;
  end

  logic all_never;
  always_comb begin
    all_never = 1'b1;
    for (int s = 0; s < NSLOT; s++)
      if (instr[s*MOVE_W + MOVE_W - 1 -: GUARD_W] != 2'b11) all_never = 1'b0;
  end

  ttm_regfile #(.DW(DW), .NREG(NREG)) rf_i (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wd(rf_wd), .rd(rf));

  ttm_fu #(.DW(DW), .IS_CMP(1'b0)) add_fu_i (
    .clk(clk), .rst_n(rst_n), .opnd_we(a_op_we), .opnd_d(a_op_d),
    .trig(a_trig), .trig_alt(a_alt), .trig_d(a_trig_d), .result(add_res));

  ttm_fu #(.DW(DW), .IS_CMP(1'b1)) cmp_fu_i (
    .clk(clk), .rst_n(rst_n), .opnd_we(c_op_we), .opnd_d(c_op_d),
    .trig(c_trig), .trig_alt(c_alt), .trig_d(c_trig_d), .result(cmp_res));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc           <= '0;
      flag         <= 1'b0;
      out_data     <= '0;
      out_valid    <= 1'b0;
      conflict_err <= 1'b0;
    end else begin
      pc        <= pc_next;
      out_valid <= out_we;
      if (flag_we) flag     <= flag_d;
      if (out_we)  out_data <= out_d;
      if (clash)   conflict_err <= 1'b1;
    end
  end

  a_r11_clash_flags: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> conflict_err);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |=> conflict_err);
  a_r9_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_redirect |=> pc == $past(pc) + PC_ONE);
  a_r8_never_guard: assert property (@(posedge clk) disable iff (!rst_n)
    all_never |-> (rf_we == '0) && !a_trig && !c_trig && !pc_redirect && !out_we);
  a_r10_out_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !out_we |=> !out_valid && $stable(out_data));
endmodule

// File: tb/ttm_core_tb_top.sv
module ttm_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 3;
  localparam int DW    = 32;
  localparam int NREG  = 8;
  localparam int PCW   = 16;
  localparam int MW    = 14;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NSLOT*MW-1:0]  instr = '0;
  logic [DW-1:0]        limm = '0;
  logic [PCW-1:0]       pc;
  logic [DW-1:0]        out_data;
  logic                 out_valid;
  logic                 conflict_err;

  ttm_core #(.NSLOT(NSLOT), .DW(DW), .NREG(NREG), .PCW(PCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .limm(limm), .pc(pc),
    .out_data(out_data), .out_valid(out_valid), .conflict_err(conflict_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state
  logic [DW-1:0]  m_rf [NREG];
  logic [DW-1:0]  m_aop, m_ares, m_cop, m_cres, m_out;
  logic           m_flag, m_outv, m_err;
  logic [PCW-1:0] m_pc;
  int nchk = 0;
  int nerr = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] mv(input int g, input int i, input int src, input int d);
    return {2'(g), 1'(i), 6'(src), 5'(d)};
  endfunction

  localparam logic [MW-1:0] NOP = {2'd0, 1'b0, 6'd0, 5'd31};

  function automatic logic [NSLOT*MW-1:0] ins(input logic [MW-1:0] a, input logic [MW-1:0] b, input logic [MW-1:0] c);
    return {c, b, a};
  endfunction

  task automatic m_reset();
    for (int r = 0; r < NREG; r++) m_rf[r] = '0;
    {m_aop, m_ares, m_cop, m_cres, m_out} = '0;
    {m_flag, m_outv, m_err} = '0;
    m_pc = '0;
  endtask

  task automatic m_step(input logic [NSLOT*MW-1:0] w, input logic [DW-1:0] li);
    logic [DW-1:0] v [NSLOT];
    logic          a [NSLOT];
    int            d [NSLOT];
    int            gp [NSLOT];
    logic [DW-1:0] nrf [NREG];
    logic [DW-1:0] naop, nares, ncop, ncres, nout;
    logic          nflag, noutv;
    logic [PCW-1:0] npc;
    for (int s = 0; s < NSLOT; s++) begin
      int g, im, sr;
      bit known;
      g  = int'(w[s*MW+12 +: 2]);
      im = int'(w[s*MW+11]);
      sr = int'(w[s*MW+5 +: 6]);
      d[s] = int'(w[s*MW +: 5]);
      if (im == 1) v[s] = (sr >= 32) ? DW'(sr - 64) : DW'(sr);
      else if (sr < NREG) v[s] = m_rf[sr];
      else if (sr == 16) v[s] = m_ares;
      else if (sr == 17) v[s] = m_cres;
      else if (sr == 18) v[s] = li;
      else if (sr == 19) v[s] = DW'(m_pc + 16'd1);
      else if (sr == 20) v[s] = DW'(m_flag);
      else v[s] = '0;
      known = (d[s] < NREG) || (d[s] >= 16 && d[s] <= 21) || (d[s] >= 24 && d[s] <= 27);
      a[s] = known && ((g == 0) || (g == 1 && m_flag) || (g == 2 && !m_flag));
      gp[s] = (d[s] == 18) ? 17 : (d[s] == 21) ? 20 : (d[s] == 25) ? 24 : d[s];
    end
    for (int r = 0; r < NREG; r++) nrf[r] = m_rf[r];
    naop = m_aop; nares = m_ares; ncop = m_cop; ncres = m_cres; nout = m_out;
    nflag = m_flag; noutv = 1'b0; npc = m_pc + 16'd1;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (a[s]) begin
        if (d[s] < NREG) nrf[d[s]] = v[s];
        else case (d[s])
          16: naop = v[s];
          17: nares = m_aop + v[s];
          18: nares = m_aop - v[s];
          19: ncop = v[s];
          20: ncres = DW'(m_cop == v[s]);
          21: ncres = DW'($signed(m_cop) < $signed(v[s]));
          24: npc = v[s][PCW-1:0];
          25: npc = m_pc + v[s][PCW-1:0];
          26: nflag = v[s][0];
          27: begin nout = v[s]; noutv = 1'b1; end
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NSLOT; i++)
      for (int j = i + 1; j < NSLOT; j++)
        if (a[i] && a[j] && gp[i] == gp[j]) m_err = 1'b1;
    for (int r = 0; r < NREG; r++) m_rf[r] = nrf[r];
    m_aop = naop; m_ares = nares; m_cop = ncop; m_cres = ncres; m_out = nout;
    m_flag = nflag; m_outv = noutv; m_pc = npc;
  endtask

  // drive one instruction, step the model, compare all outputs after the edge
  task automatic run(input logic [NSLOT*MW-1:0] w, input logic [DW-1:0] li, input string tag);
    instr = w;
    limm  = li;
    m_step(w, li);
    @(posedge clk);
    #1;
    chk({tag, " pc"}, DW'(pc), DW'(m_pc));
    chk({tag, " out_data"}, out_data, m_out);
    chk({tag, " out_valid"}, DW'(out_valid), DW'(m_outv));
    chk({tag, " err"}, DW'(conflict_err), DW'(m_err));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    m_reset();
    instr = ins(NOP, NOP, NOP);
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pc", DW'(pc), 0);
    chk("R1 out_data", out_data, 0);
    chk("R1 out_valid", DW'(out_valid), 0);
    chk("R1 err", DW'(conflict_err), 0);
    rst_n = 1'b1;

    // R3 short immediate -5 into r1, long immediate into r2
    run(ins(mv(0,1,59,1), mv(0,0,18,2), NOP), 32'h1234_5678, "R3");
    run(ins(mv(0,0,1,27), NOP, NOP), 0, "R3");
    chk("R3 short imm sign-extended", out_data, 32'hFFFF_FFFB);
    run(ins(mv(0,0,2,27), NOP, NOP), 0, "R3");
    chk("R3 long imm", out_data, 32'h1234_5678);
    // R4 swap r1 and r2 in one instruction
    run(ins(mv(0,0,1,2), mv(0,0,2,1), NOP), 0, "R4");
    run(ins(mv(0,0,1,27), NOP, NOP), 0, "R4");
    chk("R4 swap r1", out_data, 32'h1234_5678);
    run(ins(mv(0,0,2,27), NOP, NOP), 0, "R4");
    chk("R4 swap r2", out_data, 32'hFFFF_FFFB);
    // R10 output pulse lasts one cycle
    run(ins(NOP, NOP, NOP), 0, "R10");
    chk("R10 pulse ends", DW'(out_valid), 0);
    // R5 adder
    run(ins(mv(0,1,7,16), NOP, NOP), 0, "R5");
    run(ins(mv(0,1,5,17), NOP, NOP), 0, "R5");
    run(ins(mv(0,0,16,27), NOP, NOP), 0, "R5");
    chk("R5 add 7+5", out_data, 12);
    run(ins(mv(0,1,20,16), mv(0,1,1,18), NOP), 0, "R5");
    run(ins(mv(0,0,16,27), NOP, NOP), 0, "R5");
    chk("R5 sub uses old operand 7-1", out_data, 6);
    run(ins(mv(0,1,2,17), NOP, NOP), 0, "R5");
    // R7 result held
    run(ins(NOP, NOP, NOP), 0, "R7");
    run(ins(mv(0,0,16,27), NOP, NOP), 0, "R7");
    chk("R7 hold 20+2", out_data, 22);
    // R6 comparator
    run(ins(mv(0,1,61,19), NOP, NOP), 0, "R6");
    run(ins(mv(0,1,4,21), NOP, NOP), 0, "R6");
    run(ins(mv(0,0,17,27), NOP, NOP), 0, "R6");
    chk("R6 -3 lt 4", out_data, 1);
    run(ins(mv(0,1,4,20), NOP, NOP), 0, "R6");
    run(ins(mv(0,0,17,27), NOP, NOP), 0, "R6");
    chk("R6 -3 eq 4", out_data, 0);
    // R12 flag from comparator (0), R8 guards
    run(ins(mv(0,0,17,26), NOP, NOP), 0, "R12");
    run(ins(mv(1,1,9,27), mv(1,1,1,17), NOP), 0, "R8");
    chk("R8 guard false no output", DW'(out_valid), 0);
    run(ins(mv(2,1,9,27), NOP, NOP), 0, "R8");
    chk("R8 guard-not taken", out_data, 9);
    run(ins(mv(0,0,16,27), mv(3,1,3,27), NOP), 0, "R8");
    chk("R8 no trigger under false guard", out_data, 22);
    run(ins(mv(0,1,1,26), NOP, NOP), 0, "R12");
    run(ins(mv(1,0,20,27), NOP, NOP), 0, "R12");
    chk("R12 flag set", out_data, 1);
    // R9 program counter
    run(ins(mv(0,1,20,24), NOP, NOP), 0, "R9");
    chk("R9 jump", DW'(pc), 20);
    run(ins(mv(0,1,60,25), NOP, NOP), 0, "R9");
    chk("R9 relative", DW'(pc), 16);
    run(ins(mv(0,0,19,3), mv(0,0,18,24), NOP), 32'h100, "R9");
    chk("R9 call target", DW'(pc), 32'h100);
    run(ins(mv(0,0,3,27), NOP, NOP), 0, "R9");
    chk("R9 return address", out_data, 17);
    // R2 move in the highest slot
    run(ins(NOP, NOP, mv(0,1,11,27)), 0, "R2");
    chk("R2 slot2 decode", out_data, 11);
    chk("R11 no error yet", DW'(conflict_err), 0);
    // R11 conflict
    run(ins(mv(0,1,3,4), mv(0,1,6,4), NOP), 0, "R11");
    chk("R11 err set", DW'(conflict_err), 1);
    run(ins(mv(0,0,4,27), NOP, NOP), 0, "R11");
    chk("R11 lower slot wins", out_data, 3);
    chk("R11 err sticky", DW'(conflict_err), 1);

    // arbitrary move words against the model
    for (int k = 0; k < 400; k++) begin
      logic [NSLOT*MW-1:0] w;
      for (int s = 0; s < NSLOT; s++) w[s*MW +: MW] = MW'($urandom);
      run(w, $urandom, "R2 R3 R4 R5 R6 R8 R9 R11 random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule